// File: doc/BRIEF.md
# Clock Control Register File

This block holds the software-visible settings of a chip clock generator. A processor reaches it over a simple synchronous register bus with a 10-bit register number, separate read and write strobes and 32-bit data in each direction. Reads are combinational: read data is valid in the same cycle as the read strobe. Writes take effect at the clock edge that samples the write strobe. The block stores a PLL mode word, two clock control words, a clock enable word and a clock force word. It also offers a captured copy of the strap pins, a fixed identifier and a status word that is derived from the enable and force words and is not stored.

A small sequencer with three states runs the block. Reset puts it in `ST_LOAD`. On the first clock edge after reset is released it captures the strap pins, decodes them into the PLL mode word and moves to `ST_KICK`. `ST_KICK` drives the recompute request to the downstream clock ratio calculator. From `ST_KICK` or `ST_RUN`, a write to PLL mode, control 0 or control 1 moves the sequencer to `ST_KICK`. Any other cycle moves it to `ST_RUN`. Bus writes presented while the sequencer is in `ST_LOAD` are dropped, because the strap load takes that cycle. The real PLL, the clock gating and bus arbitration are handled outside this block.

Register numbers: PLL mode 0x0B0, control 0 0x0B1, control 1 0x0B2, strap 0x0B4, identifier 0x0B5, enable 0x0B9, force 0x0BA, status 0x0BB.

Top module: `clkctl_regfile`

## Requirements
- R1: After reset, control 0 reads 0x0000003C, control 1 reads 0x2B0D8800 (the full value, even though later writes are masked), and enable and force read zero. The identifier always reads 0x42051049.
- R2: At reset load, PLL mode bit 31 is set and the forward divider comes from strap bits [31:30]. Code 0 clears bit 31 and leaves bits [18:16] zero. Codes 1, 2 and 3 put 5, 4 and 2 into bits [18:16].
- R3: At reset load, strap bits [29:28] plus one go to PLL mode bits [23:20]. Strap [24:23] go to bits [27:26], strap [18:17] go to bits [25:24] and strap [22:21] go to bits [11:10]. The strap register reads back the captured pin value.
- R4: At reset load, the strap tuning code [27:25] sets PLL mode bits [4:0]: code 2 gives 0x13, code 4 gives 0x15 and code 5 gives 0x16. Any other code leaves those bits zero.
- R5: A strap value of 0x9AA40000 loads a PLL mode of 0x86240416.
- R6: Each write is ANDed with its register's mask: PLL mode 0xFFF77C3F, control 0 0x0FFFFFFE, control 1 0x00800000, and 0xBFFC0000 for both enable and force.
- R7: Writes to the strap, identifier and status registers change nothing that can be read back.
- R8: The status register reads as the inverse of (enable OR force), ANDed with 0xFFFF0000.
- R9: Reads of unmapped register numbers return zero, and so does the read data whenever the read strobe is low. Writes to unmapped register numbers change no register.
- R10: The recompute request is low in the first cycle after reset is released, high for exactly the next cycle, and then low. It is high in the cycle after each write to PLL mode, control 0 or control 1, and stays low after writes to any other register number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_i | input | 32 | Strap pin word, captured once after reset |
| bus_addr_i | input | 10 | Register number |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| recompute_o | output | 1 | Request to recompute clock ratios |

## Verification
The bench resets the block under every combination of forward divider code and tuning code. A decoder that mixed up the divider table or missed a tuning code would load a wrong PLL mode word. It writes all-ones and random data to every register number, including the read-only ones and unmapped ones. A wrong mask, or a write that leaked into a read-only register, would change a readback value. The bench also sets enable and force bits separately to exercise the status inversion, where an AND in place of an OR, or a missing upper-half mask, would be exposed. It checks the recompute request after each write and around reset, which catches a pulse that is missing, one cycle late, or raised for a register that should not trigger it.

// File: rtl/clkctl_pkg.sv
`timescale 1ns/1ps
package clkctl_pkg;

    parameter int ADDR_W = 10;
    parameter int DATA_W = 32;
    parameter int NREG   = 5;

    // writable register slots
    parameter int IDX_PLL  = 0;
    parameter int IDX_CTL0 = 1;
    parameter int IDX_CTL1 = 2;
    parameter int IDX_EN   = 3;
    parameter int IDX_FRC  = 4;

    parameter logic [ADDR_W-1:0] A_PLL   = 10'h0B0;
    parameter logic [ADDR_W-1:0] A_CTL0  = 10'h0B1;
    parameter logic [ADDR_W-1:0] A_CTL1  = 10'h0B2;
    parameter logic [ADDR_W-1:0] A_STRAP = 10'h0B4;
    parameter logic [ADDR_W-1:0] A_IDENT = 10'h0B5;
    parameter logic [ADDR_W-1:0] A_EN    = 10'h0B9;
    parameter logic [ADDR_W-1:0] A_FRC   = 10'h0BA;
    parameter logic [ADDR_W-1:0] A_STAT  = 10'h0BB;

    parameter logic [ADDR_W-1:0] SLOT_ADDR [NREG] = '{A_PLL, A_CTL0, A_CTL1, A_EN, A_FRC};
    parameter logic [DATA_W-1:0] SLOT_MASK [NREG] =
        '{32'hFFF7_7C3F, 32'h0FFF_FFFE, 32'h0080_0000, 32'hBFFC_0000, 32'hBFFC_0000};
    parameter logic [DATA_W-1:0] SLOT_RST  [NREG] =
        '{32'h0000_0000, 32'h0000_003C, 32'h2B0D_8800, 32'h0000_0000, 32'h0000_0000};

    parameter logic [DATA_W-1:0] IDENT_VAL = 32'h4205_1049;
    parameter logic [DATA_W-1:0] STAT_KEEP = 32'hFFFF_0000;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_KICK = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/clkctl_strap_decode.sv
`timescale 1ns/1ps
module clkctl_strap_decode
    import clkctl_pkg::*;
(
    input  logic [DATA_W-1:0] strap_i,
    output logic [DATA_W-1:0] pll_o
);

    logic unused_strap;
    assign unused_strap = ^{strap_i[20:19], strap_i[16:0]};

    always_comb begin
        pll_o = 32'h8000_0000;
        unique case (strap_i[31:30])
            2'd0: pll_o[31]    = 1'b0;
            2'd1: pll_o[18:16] = 3'd5;
            2'd2: pll_o[18:16] = 3'd4;
            2'd3: pll_o[18:16] = 3'd2;
        endcase
        pll_o[23:20] = {2'b00, strap_i[29:28]} + 4'd1;
        pll_o[27:26] = strap_i[24:23];
        pll_o[25:24] = strap_i[18:17];
        pll_o[11:10] = strap_i[22:21];
        case (strap_i[27:25])
            3'd2:    pll_o[4:0] = 5'h13;
            3'd4:    pll_o[4:0] = 5'h15;
            3'd5:    pll_o[4:0] = 5'h16;
            default: ;
        endcase
    end

endmodule

// File: rtl/clkctl_maskreg.sv
`timescale 1ns/1ps
module clkctl_maskreg #(
    parameter int          W    = 32,
    parameter logic [W-1:0] MASK = '1,
    parameter logic [W-1:0] RST  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         wr_i,
    input  logic [W-1:0] wr_val_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= RST;
        end else if (load_i) begin
            q_o <= load_val_i;
        end else if (wr_i) begin
            q_o <= wr_val_i & MASK;
        end
    end

endmodule

// File: rtl/clkctl_seq.sv
`timescale 1ns/1ps
module clkctl_seq
    import clkctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ratio_wr_i,
    output seq_state_t state_o,
    output logic       load_o,
    output logic       bus_en_o,
    output logic       recompute_o
);

    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: state_d = ST_KICK;
            ST_KICK: state_d = ratio_wr_i ? ST_KICK : ST_RUN;
            ST_RUN:  state_d = ratio_wr_i ? ST_KICK : ST_RUN;
        endcase
    end

    always_comb begin
        load_o      = 1'b0;
        bus_en_o    = 1'b1;
        recompute_o = 1'b0;
        unique case (state_q)
            ST_LOAD: begin
                load_o   = 1'b1;
                bus_en_o = 1'b0;
            end
            ST_KICK: recompute_o = 1'b1;
            ST_RUN:  ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/clkctl_readmux.sv
`timescale 1ns/1ps
module clkctl_readmux
    import clkctl_pkg::*;
(
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] slot_i [NREG],
    input  logic [DATA_W-1:0] strap_q_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] stat_w;
    assign stat_w = ~(slot_i[IDX_EN] | slot_i[IDX_FRC]) & STAT_KEEP;

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            case (addr_i)
                A_PLL:   rdata_o = slot_i[IDX_PLL];
                A_CTL0:  rdata_o = slot_i[IDX_CTL0];
                A_CTL1:  rdata_o = slot_i[IDX_CTL1];
                A_STRAP: rdata_o = strap_q_i;
                A_IDENT: rdata_o = IDENT_VAL;
                A_EN:    rdata_o = slot_i[IDX_EN];
                A_FRC:   rdata_o = slot_i[IDX_FRC];
                A_STAT:  rdata_o = stat_w;
                default: rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/clkctl_regfile.sv
`timescale 1ns/1ps
module clkctl_regfile
    import clkctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] strap_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_rd_i,
    input  logic              bus_wr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              recompute_o
);

    seq_state_t        state_q;
    logic              load_w;
    logic              bus_en_w;
    logic              ratio_wr_w;
    logic [NREG-1:0]   slot_wr_w;
    logic [DATA_W-1:0] slot_q [NREG];
    logic [DATA_W-1:0] pll_rst_w;
    logic [DATA_W-1:0] strap_q;
    logic [DATA_W-1:0] ctl1_q;

    clkctl_strap_decode u_dec (
        .strap_i (strap_i),
        .pll_o   (pll_rst_w)
    );

    clkctl_maskreg #(.W(DATA_W), .MASK('0), .RST('0)) u_strap (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_w),
        .load_val_i (strap_i),
        .wr_i       (1'b0),
        .wr_val_i   ('0),
        .q_o        (strap_q)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        assign slot_wr_w[g] = bus_wr_i && bus_en_w && (bus_addr_i == SLOT_ADDR[g]);
        clkctl_maskreg #(.W(DATA_W), .MASK(SLOT_MASK[g]), .RST(SLOT_RST[g])) u_reg (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     ((g == IDX_PLL) ? load_w : 1'b0),
            .load_val_i (pll_rst_w),
            .wr_i       (slot_wr_w[g]),
            .wr_val_i   (bus_wdata_i),
            .q_o        (slot_q[g])
        );
    end

    assign ratio_wr_w = slot_wr_w[IDX_PLL] | slot_wr_w[IDX_CTL0] | slot_wr_w[IDX_CTL1];
    assign ctl1_q     = slot_q[IDX_CTL1];

    clkctl_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ratio_wr_i  (ratio_wr_w),
        .state_o     (state_q),
        .load_o      (load_w),
        .bus_en_o    (bus_en_w),
        .recompute_o (recompute_o)
    );

    clkctl_readmux u_rd (
        .rd_i      (bus_rd_i),
        .addr_i    (bus_addr_i),
        .slot_i    (slot_q),
        .strap_q_i (strap_q),
        .rdata_o   (bus_rdata_o)
    );

endmodule

// File: rtl/clkctl_regfile_chk.sv
`timescale 1ns/1ps
module clkctl_regfile_chk
    import clkctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              recompute,
    input seq_state_t        state,
    input logic [DATA_W-1:0] ctl1_q,
    input logic [DATA_W-1:0] strap_q
);

    logic ratio_hit;
    assign ratio_hit = bus_wr && (state != ST_LOAD) &&
                       (bus_addr == A_PLL || bus_addr == A_CTL0 || bus_addr == A_CTL1);

    // R9
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> rdata == '0);

    // R1
    ident_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_IDENT) |-> rdata == IDENT_VAL);

    // R8
    status_low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_STAT) |-> rdata[15:0] == 16'h0);

    // R10
    kick_after_ratio_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_hit |=> recompute);

    // R10
    no_kick_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |-> !recompute);

    // R6
    ctl1_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CTL1 && state != ST_LOAD) |=>
            ctl1_q == ($past(bus_wdata) & 32'h0080_0000));

    // R7
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_LOAD) |=> $stable(strap_q));

endmodule

bind clkctl_regfile clkctl_regfile_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd_i),
    .bus_wr    (bus_wr_i),
    .bus_addr  (bus_addr_i),
    .bus_wdata (bus_wdata_i),
    .rdata     (bus_rdata_o),
    .recompute (recompute_o),
    .state     (state_q),
    .ctl1_q    (ctl1_q),
    .strap_q   (strap_q)
);

// File: tb/tb_clkctl_regfile.sv
`timescale 1ns/1ps
module tb_clkctl_regfile;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] strap;
    logic [9:0]  addr;
    logic        rd, wr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        recompute;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] m_strap, m_pll, m_c0, m_c1, m_en, m_frc;

    always #2.5 clk = ~clk;

    clkctl_regfile dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_i     (strap),
        .bus_addr_i  (addr),
        .bus_rd_i    (rd),
        .bus_wr_i    (wr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .recompute_o (recompute)
    );

    function automatic logic [31:0] ref_pll(logic [31:0] s);
        logic [31:0] r = '0;
        r[31] = (s[31:30] != 2'd0);
        case (s[31:30])
            2'd1: r[18:16] = 3'd5;
            2'd2: r[18:16] = 3'd4;
            2'd3: r[18:16] = 3'd2;
            default: r[18:16] = 3'd0;
        endcase
        r[23:20] = 4'(s[29:28]) + 4'd1;
        r[27:26] = s[24:23];
        r[25:24] = s[18:17];
        r[11:10] = s[22:21];
        if (s[27:25] == 3'd2) r[4:0] = 5'h13;
        if (s[27:25] == 3'd4) r[4:0] = 5'h15;
        if (s[27:25] == 3'd5) r[4:0] = 5'h16;
        return r;
    endfunction

    function automatic logic [31:0] ref_read(logic [9:0] a);
        case (a)
            10'h0B0: return m_pll;
            10'h0B1: return m_c0;
            10'h0B2: return m_c1;
            10'h0B4: return m_strap;
            10'h0B5: return 32'h4205_1049;
            10'h0B9: return m_en;
            10'h0BA: return m_frc;
            10'h0BB: return ~(m_en | m_frc) & 32'hFFFF_0000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(logic [9:0] a);
        case (a)
            10'h0B0, 10'h0B1, 10'h0B2, 10'h0B9, 10'h0BA: return "R6";
            10'h0B4, 10'h0B5: return "R7";
            10'h0BB: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_read(logic [9:0] a, string req);
        addr = a; rd = 1'b1;
        #1 chk(req, rdata, ref_read(a));
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic do_write(logic [9:0] a, logic [31:0] d);
        bit kick;
        kick = (a == 10'h0B0 || a == 10'h0B1 || a == 10'h0B2);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        #1 chk("R10", {31'b0, recompute}, {31'b0, kick});
        case (a)
            10'h0B0: m_pll = d & 32'hFFF7_7C3F;
            10'h0B1: m_c0  = d & 32'h0FFF_FFFE;
            10'h0B2: m_c1  = d & 32'h0080_0000;
            10'h0B9: m_en  = d & 32'hBFFC_0000;
            10'h0BA: m_frc = d & 32'hBFFC_0000;
            default: ;
        endcase
    endtask

    task automatic do_reset(logic [31:0] s);
        rd = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        rst_n = 1'b0; strap = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R10", {31'b0, recompute}, 32'h0);
        @(negedge clk);
        #1 chk("R10", {31'b0, recompute}, 32'h1);
        @(negedge clk);
        #1 chk("R10", {31'b0, recompute}, 32'h0);
        m_strap = s; m_pll = ref_pll(s);
        m_c0 = 32'h0000_003C; m_c1 = 32'h2B0D_8800; m_en = '0; m_frc = '0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [9:0] map [8];
        map = '{10'h0B0, 10'h0B1, 10'h0B2, 10'h0B4, 10'h0B5, 10'h0B9, 10'h0BA, 10'h0BB};
        void'($urandom(32'd2718));
        rst_n = 1'b0; rd = 1'b0; wr = 1'b0; addr = '0; wdata = '0; strap = '0;

        // R5 default strap, literal expectation
        do_reset(32'h9AA4_0000);
        addr = 10'h0B0; rd = 1'b1;
        #1 chk("R5", rdata, 32'h8624_0416);
        @(negedge clk); rd = 1'b0;
        // R1 reset values
        do_read(10'h0B1, "R1");
        do_read(10'h0B2, "R1");
        do_read(10'h0B9, "R1");
        do_read(10'h0BA, "R1");
        do_read(10'h0B5, "R1");
        do_read(10'h0B4, "R3");
        // R8 status with nothing enabled
        do_read(10'h0BB, "R8");
        // R9 idle read data
        addr = 10'h0B5; rd = 1'b0;
        #1 chk("R9", rdata, 32'h0);
        @(negedge clk);

        // R2 R4 every forward and tuning code, R3 other fields random
        for (int f = 0; f < 4; f++) begin
            for (int t = 0; t < 8; t++) begin
                logic [31:0] s;
                s = $urandom();
                s[31:30] = 2'(f);
                s[27:25] = 3'(t);
                do_reset(s);
                do_read(10'h0B0, (t == 2 || t == 4 || t == 5) ? "R4" : "R2");
                do_read(10'h0B4, "R3");
            end
        end

        // R6 all-ones through every mask
        do_reset(32'h9AA4_0000);
        for (int i = 0; i < 8; i++) begin
            do_write(map[i], 32'hFFFF_FFFF);
            do_read(map[i], req_of(map[i]));
        end
        // R7 read-only registers keep their values
        do_write(10'h0B5, 32'h0);
        do_write(10'h0B4, 32'h1234_5678);
        do_write(10'h0BB, 32'h0);
        do_read(10'h0B4, "R7");
        do_read(10'h0B5, "R7");
        // R8 enable alone, force alone
        do_write(10'h0BA, 32'h0);
        do_write(10'h0B9, 32'h8004_0000);
        do_read(10'h0BB, "R8");
        do_write(10'h0B9, 32'h0);
        do_write(10'h0BA, 32'h2010_0000);
        do_read(10'h0BB, "R8");
        // R9 unmapped writes leave every mapped register alone
        do_write(10'h0B3, 32'hFFFF_FFFF);
        do_write(10'h0B8, 32'hFFFF_FFFF);
        do_write(10'h3FF, 32'hFFFF_FFFF);
        for (int i = 0; i < 8; i++) do_read(map[i], "R9");
        do_read(10'h0B3, "R9");
        do_read(10'h000, "R9");

        // random mix of mapped and unmapped accesses
        for (int k = 0; k < 600; k++) begin
            logic [9:0] a;
            a = ($urandom_range(0, 3) == 0) ? 10'($urandom()) : map[$urandom_range(0, 7)];
            if ($urandom_range(0, 1) == 0) do_write(a, $urandom());
            else                           do_read(a, req_of(a));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule